// File: doc/BRIEF.md
# Twelve-channel PWM dimmer with log or linear gain

This block produces the on/off enables for a row of constant-current LED sources. One 7-bit brightness code is shared by all channels. It is turned into a duty cycle through an exponential curve or a straight line, depending on a mode input. A pair of rate inputs sets the length of the dimming period to one, two or four times a base count of timing ticks. The tick is a one-cycle strobe supplied from outside at the dimming resolution.

Each channel has an on bit and a PWM bit. A channel whose PWM bit is clear, or any channel while the global PWM enable is low, is driven steadily by its on bit. Otherwise it follows the shared waveform, gated by its on bit. The code, the curve choice and the rate are sampled only when a period starts, so a change never cuts a pulse short. The channels are switched in pairs. Each pair moves one tick after the pair before it, which spreads the current steps in time.

Top module: `led_pwm_dimmer`

## Requirements
- R1: While reset is high, and after reset until the block is driven, all channel enables are 0.
- R2: A channel whose PWM bit is 0 carries its on bit steadily.
- R3: A channel whose on bit is 0 stays 0, whatever the waveform and its PWM bit are.
- R4: The period in ticks is BASE_TICKS when rate_fast=1, 2×BASE_TICKS when rate_fast=0 and rate_mid=1, and 4×BASE_TICKS when both are 0. The fast bit has priority.
- R5: With lin_sel=1, the high time per period is round(P×code/127) ticks, where P is the period length.
- R6: With lin_sel=0, the high time per period is round(P×0.9471^(127−code)) ticks, within one tick.
- R7: Code 0 gives no high tick in a period and code 127 gives a high level for the whole period, in both modes.
- R8: The code, curve and rate take effect only at the first tick of the next period. Once settled, the high time starts on period tick 0.
- R9: Channels 2k and 2k+1 switch together, k ticks after channels 0 and 1. Channel 0 reflects a change on its on bit two clock edges after that change when a tick is present every cycle.
- R10: With pwm_on=0, every channel carries its on bit steadily. Raising pwm_on brings the waveform back with the PWM bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe at the dimming resolution |
| gain | input | 7 | Shared brightness code, 0 to 127 |
| rate_fast | input | 1 | Selects a period of BASE_TICKS |
| rate_mid | input | 1 | Selects 2×BASE_TICKS when rate_fast is 0 |
| lin_sel | input | 1 | 1 = linear curve, 0 = exponential curve |
| pwm_on | input | 1 | Global PWM enable |
| ch_on | input | N_CH | Per-channel on bits |
| ch_pwm | input | N_CH | Per-channel PWM bits |
| ch_en | output | N_CH | Registered channel enables |

## Verification
A wrong period counter or wrong sampling of the settings shows at the ports within one period. It appears as a wrong spacing between rising edges of a PWM channel, or as a level change before the period boundary right after the code moves. A wrong entry in the curve tables shows only for the code that selects it, as a high-tick count off by more than one. The bench therefore sweeps both curves over random codes and rates. A wrong tap in the pair delay line shows within a few cycles as a shifted or split rising edge when all on bits rise together.

// File: rtl/pwmdim_pkg.sv
package pwmdim_pkg;
  localparam int CODE_W   = 7;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int FRAC_W   = 24;
  // 0.9471 in Q24, step ratio between adjacent log codes
  localparam longint ALPHA_Q = 64'd15889701;

  typedef enum logic [1:0] {RATE_SLOW, RATE_MID, RATE_FAST} rate_e;

  // Q24 fraction of the period for a code on the exponential curve
  function automatic logic [FRAC_W:0] log_frac(input int code);
    longint v;
    v = longint'(1) << FRAC_W;
    for (int k = code; k < CODE_MAX; k++)
      v = (v * ALPHA_Q + (longint'(1) << (FRAC_W - 1))) >>> FRAC_W;
    return (FRAC_W + 1)'(v);
  endfunction

  // Q24 fraction of the period for a code on the straight line
  function automatic logic [FRAC_W:0] lin_frac(input int code);
    longint v;
    v = ((longint'(code) << FRAC_W) + longint'(CODE_MAX / 2)) / longint'(CODE_MAX);
    return (FRAC_W + 1)'(v);
  endfunction
endpackage

// File: rtl/pwmdim_curve.sv
module pwmdim_curve
  import pwmdim_pkg::*;
#(
  parameter int BASE_TICKS = 5000,
  parameter int PER_W      = $clog2(4 * BASE_TICKS + 1)
) (
  input  rate_e              rate,
  input  logic               lin,
  input  logic [CODE_W-1:0]  code,
  output logic [PER_W-1:0]   per,
  output logic [PER_W-1:0]   thr
);
  localparam int N_CODE = CODE_MAX + 1;
  localparam int PROD_W = PER_W + FRAC_W + 1;

  logic [FRAC_W:0]   log_t [N_CODE];
  logic [FRAC_W:0]   lin_t [N_CODE];
  logic [FRAC_W:0]   frac;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] rnd;

  for (genvar g = 0; g < N_CODE; g++) begin : g_tab
    assign log_t[g] = log_frac(g);
    assign lin_t[g] = lin_frac(g);
  end

  always_comb begin
    unique case (rate)
      RATE_FAST: per = PER_W'(BASE_TICKS);
      RATE_MID:  per = PER_W'(2 * BASE_TICKS);
      default:   per = PER_W'(4 * BASE_TICKS);
    endcase
  end

  always_comb begin
    if (code == '0)  frac = '0;
    else if (lin)    frac = lin_t[code];
    else             frac = log_t[code];
  end

  assign prod = PROD_W'(per) * PROD_W'(frac);
  assign rnd  = prod + PROD_W'(longint'(1) << (FRAC_W - 1));
  assign thr  = rnd[FRAC_W +: PER_W];
endmodule

// File: rtl/pwmdim_phase.sv
module pwmdim_phase
  import pwmdim_pkg::*;
#(
  parameter int BASE_TICKS = 5000,
  parameter int PER_W      = $clog2(4 * BASE_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] gain_in,
  input  logic              lin_in,
  input  rate_e             rate_in,
  input  logic [PER_W-1:0]  per,
  input  logic [PER_W-1:0]  thr,
  output logic [CODE_W-1:0] code_q,
  output logic              lin_q,
  output rate_e             rate_q,
  output logic              wave
);
  logic [PER_W-1:0] cnt;
  logic             armed;
  logic             wrap;

  assign wrap = !armed || (cnt == per - PER_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      armed  <= 1'b0;
      code_q <= '0;
      lin_q  <= 1'b0;
      rate_q <= RATE_SLOW;
    end else if (tick) begin
      if (wrap) begin
        cnt    <= '0;
        armed  <= 1'b1;
        code_q <= gain_in;
        lin_q  <= lin_in;
        rate_q <= rate_in;
      end else begin
        cnt <= cnt + PER_W'(1);
      end
    end
  end

  assign wave = armed && (cnt < thr);

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cnt < per));
  p_hold_settings_r8: assert property (@(posedge clk) disable iff (rst)
    !(tick && wrap) |=> ($stable(code_q) && $stable(lin_q) && $stable(rate_q)));
  p_code_zero_dark_r7: assert property (@(posedge clk) disable iff (rst)
    (code_q == '0) |-> !wave);
  p_code_full_lit_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && code_q == CODE_W'(CODE_MAX)) |-> wave);
endmodule

// File: rtl/pwmdim_stagger.sv
module pwmdim_stagger #(
  parameter int N_CH   = 12,
  parameter int N_PAIR = (N_CH + 1) / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            wave,
  input  logic            pwm_on,
  input  logic [N_CH-1:0] ch_on,
  input  logic [N_CH-1:0] ch_pwm,
  output logic [N_CH-1:0] ch_en
);
  logic [N_CH-1:0] wanted;
  logic [N_CH-1:0] dly [N_PAIR];
  logic [N_CH-1:0] tap;

  assign wanted = ch_on & (~(ch_pwm & {N_CH{pwm_on}}) | {N_CH{wave}});

  for (genvar s = 0; s < N_PAIR; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)       dly[s] <= '0;
        else if (tick) dly[s] <= wanted;
      end
    end else begin : g_link
      always_ff @(posedge clk) begin
        if (rst)       dly[s] <= '0;
        else if (tick) dly[s] <= dly[s-1];
      end
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_tap
    assign tap[c] = dly[c/2][c];
  end

  always_ff @(posedge clk) begin
    if (rst) ch_en <= '0;
    else     ch_en <= tap;
  end

  p_moves_on_tick_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(tick, 2) |-> $stable(ch_en));
endmodule

// File: rtl/led_pwm_dimmer.sv
module led_pwm_dimmer
  import pwmdim_pkg::*;
#(
  parameter int N_CH       = 12,
  parameter int BASE_TICKS = 5000,
  parameter int PER_W      = $clog2(4 * BASE_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] gain,
  input  logic              rate_fast,
  input  logic              rate_mid,
  input  logic              lin_sel,
  input  logic              pwm_on,
  input  logic [N_CH-1:0]   ch_on,
  input  logic [N_CH-1:0]   ch_pwm,
  output logic [N_CH-1:0]   ch_en
);
  rate_e             rate_in;
  rate_e             rate_q;
  logic [CODE_W-1:0] code_q;
  logic              lin_q;
  logic [PER_W-1:0]  per;
  logic [PER_W-1:0]  thr;
  logic              wave;

  always_comb begin
    if (rate_fast)     rate_in = RATE_FAST;
    else if (rate_mid) rate_in = RATE_MID;
    else               rate_in = RATE_SLOW;
  end

  pwmdim_curve #(.BASE_TICKS(BASE_TICKS), .PER_W(PER_W)) u_curve (
    .rate (rate_q),
    .lin  (lin_q),
    .code (code_q),
    .per  (per),
    .thr  (thr)
  );

  pwmdim_phase #(.BASE_TICKS(BASE_TICKS), .PER_W(PER_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .gain_in (gain),
    .lin_in  (lin_sel),
    .rate_in (rate_in),
    .per     (per),
    .thr     (thr),
    .code_q  (code_q),
    .lin_q   (lin_q),
    .rate_q  (rate_q),
    .wave    (wave)
  );

  pwmdim_stagger #(.N_CH(N_CH)) u_stagger (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .wave   (wave),
    .pwm_on (pwm_on),
    .ch_on  (ch_on),
    .ch_pwm (ch_pwm),
    .ch_en  (ch_en)
  );

  p_reset_dark_r1: assert property (@(posedge clk)
    $past(rst) |-> (ch_en == '0));
endmodule

// File: tb/sim_led_pwm_dimmer.sv
module sim_led_pwm_dimmer;
  localparam int N_CH = 12;
  localparam int BASE = 250;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            tick = 1'b0;
  logic [6:0]      gain = '0;
  logic            rate_fast = 1'b0;
  logic            rate_mid = 1'b0;
  logic            lin_sel = 1'b0;
  logic            pwm_on = 1'b0;
  logic [N_CH-1:0] ch_on = '0;
  logic [N_CH-1:0] ch_pwm = '0;
  logic [N_CH-1:0] ch_en;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  led_pwm_dimmer #(.N_CH(N_CH), .BASE_TICKS(BASE)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .gain(gain), .rate_fast(rate_fast),
    .rate_mid(rate_mid), .lin_sel(lin_sel), .pwm_on(pwm_on), .ch_on(ch_on),
    .ch_pwm(ch_pwm), .ch_en(ch_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int per_of(input bit f, input bit m);
    if (f) return BASE;
    if (m) return 2 * BASE;
    return 4 * BASE;
  endfunction

  function automatic int exp_on(input int code, input bit lin, input int p);
    real r;
    if (code == 0) return 0;
    if (code == 127) return p;
    if (lin) r = p * code / 127.0;
    else     r = p * (0.9471 ** (127 - code));
    return $rtoi(r + 0.5);
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic count_on(input int p, output int n);
    repeat (4 * BASE + 20) @(negedge clk);
    n = 0;
    repeat (p) begin
      @(negedge clk);
      if (ch_en[0]) n++;
    end
  endtask

  task automatic run_duty(input int code, input bit lin, input bit f, input bit m,
                          input string req);
    int n, e, p;
    gain = 7'(code); lin_sel = lin; rate_fast = f; rate_mid = m;
    p = per_of(f, m);
    count_on(p, n);
    e = exp_on(code, lin, p);
    chk(iabs(n - e) <= 1, req, n, e);
  endtask

  task automatic rise_gap(input bit f, input bit m);
    int c0, c1, cyc;
    rate_fast = f; rate_mid = m; lin_sel = 1'b1; gain = 7'd64;
    repeat (4 * BASE + 20) @(negedge clk);
    cyc = 0;
    while (ch_en[0]) begin @(negedge clk); cyc++; end
    while (!ch_en[0]) begin @(negedge clk); cyc++; end
    c0 = cyc;
    while (ch_en[0]) begin @(negedge clk); cyc++; end
    while (!ch_en[0]) begin @(negedge clk); cyc++; end
    c1 = cyc;
    chk((c1 - c0) == per_of(f, m), "R4 period", c1 - c0, per_of(f, m));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rise [N_CH];
    int stuck, n, e, thr_e;
    bit flat;
    logic [N_CH-1:0] mask;
    void'($urandom(32'd20240607));

    repeat (4) @(negedge clk);
    chk(ch_en == '0, "R1 reset", int'(ch_en), 0);
    rst = 1'b0;
    tick = 1'b1;
    repeat (3) @(negedge clk);
    chk(ch_en == '0, "R1 after reset", int'(ch_en), 0);

    // R2: PWM bits clear -> steady on bits
    pwm_on = 1'b1; gain = 7'd40; ch_pwm = '0; ch_on = 12'hA5C;
    repeat (20) @(negedge clk);
    flat = 1'b1;
    repeat (1200) begin @(negedge clk); if (ch_en != 12'hA5C) flat = 1'b0; end
    chk(flat, "R2 steady on bits", int'(ch_en), 'hA5C);

    // R9: stagger, all on bits rise together
    ch_on = '0;
    repeat (10) @(negedge clk);
    for (int c = 0; c < N_CH; c++) rise[c] = -1;
    ch_on = '1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      for (int c = 0; c < N_CH; c++) if (ch_en[c] && rise[c] < 0) rise[c] = k;
    end
    chk(rise[0] == 2, "R9 first pair latency", rise[0], 2);
    for (int c = 1; c < N_CH; c++)
      chk(rise[c] - rise[0] == c / 2, "R9 pair skew", rise[c] - rise[0], c / 2);

    // R7 corners and R4 rates
    ch_on = 12'h001; ch_pwm = 12'h001; pwm_on = 1'b1;
    run_duty(0,   1'b0, 1'b1, 1'b0, "R7 code0 log");
    run_duty(0,   1'b1, 1'b0, 1'b1, "R7 code0 lin");
    run_duty(127, 1'b0, 1'b0, 1'b0, "R7 code127 log");
    run_duty(127, 1'b1, 1'b1, 1'b0, "R7 code127 lin");
    run_duty(1,   1'b0, 1'b0, 1'b0, "R6 log code1");
    run_duty(1,   1'b1, 1'b0, 1'b0, "R5 lin code1");
    rise_gap(1'b0, 1'b0);
    rise_gap(1'b0, 1'b1);
    rise_gap(1'b1, 1'b0);
    rise_gap(1'b1, 1'b1);

    // R5 / R6 random sweep
    for (int i = 0; i < 30; i++) begin
      int code;
      bit lin, f, m;
      code = int'($urandom % 128);
      lin  = 1'($urandom);
      f    = 1'($urandom);
      m    = 1'($urandom);
      run_duty(code, lin, f, m, lin ? "R5 linear duty" : "R6 log duty");
    end

    // R8: code change mid period waits for the boundary
    rate_fast = 1'b1; rate_mid = 1'b0; lin_sel = 1'b1; gain = 7'd64;
    repeat (4 * BASE + 20) @(negedge clk);
    while (!ch_en[0]) @(negedge clk);
    while (ch_en[0]) @(negedge clk);
    gain = 7'd127;
    thr_e = exp_on(64, 1'b1, BASE);
    stuck = 0;
    repeat (BASE - thr_e - 3) begin @(negedge clk); if (ch_en[0]) stuck++; end
    chk(stuck == 0, "R8 held until boundary", stuck, 0);
    repeat (6) @(negedge clk);
    chk(ch_en[0] == 1'b1, "R8 applied at boundary", int'(ch_en[0]), 1);

    // R3: on bit 0 with PWM bit 1 stays dark
    gain = 7'd127; ch_on = 12'h001; ch_pwm = 12'h003;
    repeat (4 * BASE + 20) @(negedge clk);
    stuck = 0;
    repeat (BASE) begin @(negedge clk); if (ch_en[1]) stuck++; end
    chk(stuck == 0, "R3 on bit clear", stuck, 0);
    chk(ch_en[0] == 1'b1, "R3 neighbour lit", int'(ch_en[0]), 1);

    // R10: global disable, then resume
    mask = 12'($urandom) | 12'h001;
    ch_on = mask; ch_pwm = '1; gain = 7'd30; lin_sel = 1'b1; pwm_on = 1'b0;
    repeat (20) @(negedge clk);
    flat = 1'b1;
    repeat (2 * BASE) begin @(negedge clk); if (ch_en != mask) flat = 1'b0; end
    chk(flat, "R10 disabled steady", int'(ch_en), int'(mask));
    pwm_on = 1'b1;
    count_on(BASE, n);
    e = exp_on(30, 1'b1, BASE);
    chk(iabs(n - e) <= 1, "R10 resumed PWM", n, e);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule